// File: doc/BRIEF.md
# FMA Special-Operand Resolver

This block sits at the front of a double-precision fused multiply-add unit that computes `z + x*y`, or `z - x*y` when the negate-product input is set. It sorts each of the three 64-bit operands into one of six classes: signalling NaN, quiet NaN, infinity, zero, denormal or normal. From these classes it decides whether special values alone fix the result. When they do, it produces the final encoding and the invalid-operation flag and raises `res_handled`. When they do not, it lowers `res_handled` and leaves the work to the finite arithmetic datapath.

Classification uses the standard binary64 layout. The sign is bit 63 and the exponent is bits 62:52. An exponent of all ones with a zero fraction is infinity. An exponent of all ones with a non-zero fraction is a NaN, and fraction bit 51 marks it as quiet (1) or signalling (0). An exponent of zero with a non-zero fraction is denormal. Denormals are treated as ordinary non-zero finite values and are not flushed.

All results are registered once, so each answer belongs to the operands presented one clock earlier.

Top module: `fma_special_resolver`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after it, `res_handled`, `res_invalid` and `res_value` are all zero.
- R2: If any operand is a signalling NaN, the first of z, x, y (in that order) that is one is returned with fraction bit 51 forced to 1, together with `res_invalid`=1 and `res_handled`=1.
- R3: If no operand is a signalling NaN but at least one is a quiet NaN, the first of z, x, y that is a quiet NaN is returned bit-for-bit, with `res_invalid`=0 and `res_handled`=1.
- R4: Without NaNs, an infinity multiplied by a zero (in either operand order) returns the default NaN 0x7FF8000000000000 with `res_invalid`=1.
- R5: The effective product sign is sign(x) XOR sign(y) XOR `neg_prod`. An infinite product meeting an infinite z of the opposite effective sign returns the default NaN with `res_invalid`=1.
- R6: In every other case with an infinite product, the result is an infinity carrying the effective product sign, with `res_invalid`=0.
- R7: A finite non-zero product (normal or denormal factors) with an infinite z returns z unchanged.
- R8: A zero product with an infinite or a non-zero finite z returns z unchanged.
- R9: A zero product with a zero z returns z when the sign of z equals the effective product sign. Otherwise it returns +0, or -0 when `rnd_down` is 1.
- R10: A finite non-zero product with a finite z (zero included) yields `res_handled`=0, `res_invalid`=0 and `res_value`=0.
- R11: Each output reflects the operands and controls sampled at the preceding rising clock edge, one cycle of latency, with no other delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_z | input | 64 | Addend operand |
| op_x | input | 64 | First multiplicand |
| op_y | input | 64 | Second multiplicand |
| neg_prod | input | 1 | Invert the product sign (multiply-subtract) |
| rnd_down | input | 1 | Rounding toward minus infinity is active |
| res_handled | output | 1 | Result is fully decided by special operands |
| res_invalid | output | 1 | Invalid-operation exception |
| res_value | output | 64 | Resolved result, zero when not handled |

## Verification
Every result is due exactly one rising edge after its operands are applied. The bench drives a new operand set on a falling edge and compares all three outputs on the next falling edge, which falls after the single register stage has loaded. Operand sets are then applied back to back, so a stale or extra register stage would make the comparison land on the wrong vector. The R1 check samples during reset, before any operand is driven.

// File: rtl/fmasr_pkg.sv
package fmasr_pkg;

    typedef enum logic [2:0] {
        FC_ZERO = 3'd0,
        FC_DNRM = 3'd1,
        FC_NORM = 3'd2,
        FC_INF  = 3'd3,
        FC_QNAN = 3'd4,
        FC_SNAN = 3'd5
    } fclass_e;

    localparam int unsigned N_OPS = 3;
    localparam int unsigned IDX_Z = 0;
    localparam int unsigned IDX_X = 1;
    localparam int unsigned IDX_Y = 2;

endpackage

// File: rtl/fmasr_classify.sv
module fmasr_classify
    import fmasr_pkg::*;
#(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output fclass_e               cls,
    output logic                  sgn
);
    localparam int unsigned W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo = operand[W-2:FRAC_W];
    assign frac = operand[FRAC_W-1:0];
    assign sgn  = operand[W-1];

    always_comb begin
        if (&expo) begin
            if (frac == '0)            cls = FC_INF;
            else if (frac[FRAC_W-1])   cls = FC_QNAN;
            else                       cls = FC_SNAN;
        end else if (expo == '0) begin
            cls = (frac == '0) ? FC_ZERO : FC_DNRM;
        end else begin
            cls = FC_NORM;
        end
    end

endmodule

// File: rtl/fmasr_nan_pick.sv
module fmasr_nan_pick
    import fmasr_pkg::*;
#(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] ops [N_OPS],
    input  fclass_e               cls [N_OPS],
    output logic                  nan_hit,
    output logic                  nan_inv,
    output logic [EXP_W+FRAC_W:0] nan_val
);
    localparam int unsigned W = EXP_W + FRAC_W + 1;
    localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);

    logic           s_found, q_found;
    logic [W-1:0]   s_val, q_val;

    // Lowest index wins within each kind: z, then x, then y.
    always_comb begin
        s_found = 1'b0;
        q_found = 1'b0;
        s_val   = '0;
        q_val   = '0;
        for (int i = 0; i < int'(N_OPS); i++) begin
            if (cls[i] == FC_SNAN && !s_found) begin
                s_found = 1'b1;
                s_val   = ops[i] | QUIET_BIT;
            end
            if (cls[i] == FC_QNAN && !q_found) begin
                q_found = 1'b1;
                q_val   = ops[i];
            end
        end
    end

    assign nan_hit = s_found | q_found;
    assign nan_inv = s_found;
    assign nan_val = s_found ? s_val : q_val;

endmodule

// File: rtl/fmasr_special.sv
module fmasr_special
    import fmasr_pkg::*;
#(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52,
    parameter logic [EXP_W+FRAC_W:0] DFLT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
    input  fclass_e               cls_z,
    input  fclass_e               cls_x,
    input  fclass_e               cls_y,
    input  logic                  sgn_z,
    input  logic                  sgn_x,
    input  logic                  sgn_y,
    input  logic [EXP_W+FRAC_W:0] op_z,
    input  logic                  neg_prod,
    input  logic                  rnd_down,
    output logic                  sp_hit,
    output logic                  sp_inv,
    output logic [EXP_W+FRAC_W:0] sp_val
);
    localparam int unsigned W = EXP_W + FRAC_W + 1;

    logic prod_sgn, prod_inf, prod_zero, z_inf, z_zero;

    assign prod_sgn  = sgn_x ^ sgn_y ^ neg_prod;
    assign prod_inf  = (cls_x == FC_INF)  || (cls_y == FC_INF);
    assign prod_zero = (cls_x == FC_ZERO) || (cls_y == FC_ZERO);
    assign z_inf     = (cls_z == FC_INF);
    assign z_zero    = (cls_z == FC_ZERO);

    always_comb begin
        sp_hit = 1'b1;
        sp_inv = 1'b0;
        sp_val = '0;
        if (prod_inf && prod_zero) begin
            sp_inv = 1'b1;
            sp_val = DFLT_NAN;
        end else if (prod_inf) begin
            if (z_inf && (sgn_z != prod_sgn)) begin
                sp_inv = 1'b1;
                sp_val = DFLT_NAN;
            end else begin
                sp_val = {prod_sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end
        end else if (prod_zero) begin
            if (z_zero && (sgn_z != prod_sgn))
                sp_val = {rnd_down, {(W-1){1'b0}}};
            else
                sp_val = op_z;
        end else if (z_inf) begin
            sp_val = op_z;
        end else begin
            sp_hit = 1'b0;
        end
    end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fmasr_pkg::*;
#(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52,
    parameter logic [EXP_W+FRAC_W:0] DFLT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXP_W+FRAC_W:0] op_z,
    input  logic [EXP_W+FRAC_W:0] op_x,
    input  logic [EXP_W+FRAC_W:0] op_y,
    input  logic                  neg_prod,
    input  logic                  rnd_down,
    output logic                  res_handled,
    output logic                  res_invalid,
    output logic [EXP_W+FRAC_W:0] res_value
);
    localparam int unsigned W = EXP_W + FRAC_W + 1;

    typedef struct packed {
        logic         handled;
        logic         invalid;
        logic [W-1:0] value;
        logic         started;
    } state_t;

    logic [W-1:0] ops [N_OPS];
    fclass_e      cls [N_OPS];
    logic         sgn [N_OPS];

    assign ops[IDX_Z] = op_z;
    assign ops[IDX_X] = op_x;
    assign ops[IDX_Y] = op_y;

    for (genvar g = 0; g < int'(N_OPS); g++) begin : g_cls
        fmasr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .operand (ops[g]),
            .cls     (cls[g]),
            .sgn     (sgn[g])
        );
    end

    logic         nan_hit, nan_inv;
    logic [W-1:0] nan_val;

    fmasr_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
        .ops     (ops),
        .cls     (cls),
        .nan_hit (nan_hit),
        .nan_inv (nan_inv),
        .nan_val (nan_val)
    );

    logic         sp_hit, sp_inv;
    logic [W-1:0] sp_val;

    fmasr_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DFLT_NAN(DFLT_NAN)) u_sp (
        .cls_z    (cls[IDX_Z]),
        .cls_x    (cls[IDX_X]),
        .cls_y    (cls[IDX_Y]),
        .sgn_z    (sgn[IDX_Z]),
        .sgn_x    (sgn[IDX_X]),
        .sgn_y    (sgn[IDX_Y]),
        .op_z     (op_z),
        .neg_prod (neg_prod),
        .rnd_down (rnd_down),
        .sp_hit   (sp_hit),
        .sp_inv   (sp_inv),
        .sp_val   (sp_val)
    );

    state_t st_d, st_q;

    always_comb begin
        st_d         = '0;
        st_d.started = 1'b1;
        if (nan_hit) begin
            st_d.handled = 1'b1;
            st_d.invalid = nan_inv;
            st_d.value   = nan_val;
        end else if (sp_hit) begin
            st_d.handled = 1'b1;
            st_d.invalid = sp_inv;
            st_d.value   = sp_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_handled = st_q.handled;
    assign res_invalid = st_q.invalid;
    assign res_value   = st_q.value;

    logic any_snan, any_qnan, any_nan_free_zero_prod;
    always_comb begin
        any_snan = 1'b0;
        any_qnan = 1'b0;
        for (int i = 0; i < int'(N_OPS); i++) begin
            any_snan = any_snan | (cls[i] == FC_SNAN);
            any_qnan = any_qnan | (cls[i] == FC_QNAN);
        end
        any_nan_free_zero_prod = !any_snan && !any_qnan
            && (cls[IDX_X] == FC_ZERO || cls[IDX_Y] == FC_ZERO)
            && cls[IDX_X] != FC_INF && cls[IDX_Y] != FC_INF
            && cls[IDX_Z] != FC_ZERO;
    end

    // R2
    snan_raises_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started && $past(any_snan) |-> res_invalid && res_handled);

    // R3
    qnan_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started && $past(any_qnan && !any_snan) |-> !res_invalid && res_handled);

    // R4
    invalid_gives_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_invalid |-> (&res_value[W-2:FRAC_W]) && res_value[FRAC_W-1] && res_handled);

    // R8
    zero_prod_passes_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started && $past(any_nan_free_zero_prod) |-> res_value == $past(op_z));

    // R10
    unhandled_is_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_handled |-> res_value == '0 && !res_invalid);

endmodule

// File: tb/fma_special_resolver_tb.sv
module fma_special_resolver_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_z = '0, op_x = '0, op_y = '0;
    logic        neg_prod = 1'b0, rnd_down = 1'b0;
    logic        res_handled, res_invalid;
    logic [63:0] res_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

    always #5 clk = ~clk;

    fma_special_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .op_z(op_z), .op_x(op_x), .op_y(op_y),
        .neg_prod(neg_prod), .rnd_down(rnd_down),
        .res_handled(res_handled), .res_invalid(res_invalid), .res_value(res_value)
    );

    // kinds: 0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signalling NaN
    function automatic logic [63:0] mk(input int kind, input bit s);
        logic [63:0] r;
        logic [10:0] e;
        r = {$urandom, $urandom};
        e = 11'(1 + ($urandom % 2046));
        case (kind)
            0: return {s, 63'd0};
            1: return {s, 11'd0, r[51:1], 1'b1};
            2: return {s, e, r[51:0]};
            3: return {s, 11'h7FF, 52'd0};
            4: return {s, 11'h7FF, 1'b1, r[50:0]};
            default: return {s, 11'h7FF, 1'b0, r[50:1], 1'b1};
        endcase
    endfunction

    function automatic int kind_of(input logic [63:0] v);
        if (v[62:52] == 11'h7FF) begin
            if (v[51:0] == 0) return 3;
            return v[51] ? 4 : 5;
        end
        if (v[62:52] == 0) return (v[51:0] == 0) ? 0 : 1;
        return 2;
    endfunction

    task automatic expect_of(input logic [63:0] z, x, y, input bit n, rd,
                             output logic [63:0] v, output bit h, output bit inv,
                             output string tag);
        int kz, kx, ky;
        bit ps;
        kz = kind_of(z); kx = kind_of(x); ky = kind_of(y);
        ps = x[63] ^ y[63] ^ n;
        h = 1; inv = 0; v = 0;
        if (kz == 5)      begin v = z | (64'd1 << 51); inv = 1; tag = "R2"; end
        else if (kx == 5) begin v = x | (64'd1 << 51); inv = 1; tag = "R2"; end
        else if (ky == 5) begin v = y | (64'd1 << 51); inv = 1; tag = "R2"; end
        else if (kz == 4) begin v = z; tag = "R3"; end
        else if (kx == 4) begin v = x; tag = "R3"; end
        else if (ky == 4) begin v = y; tag = "R3"; end
        else if ((kx == 3 && ky == 0) || (kx == 0 && ky == 3)) begin
            v = DNAN; inv = 1; tag = "R4";
        end else if (kx == 3 || ky == 3) begin
            if (kz == 3 && z[63] != ps) begin v = DNAN; inv = 1; tag = "R5"; end
            else begin v = {ps, 11'h7FF, 52'd0}; tag = "R6"; end
        end else if (kx == 0 || ky == 0) begin
            if (kz == 0) begin
                tag = "R9";
                v = (z[63] == ps) ? z : {rd, 63'd0};
            end else begin v = z; tag = "R8"; end
        end else if (kz == 3) begin v = z; tag = "R7"; end
        else begin h = 0; tag = "R10"; end
    endtask

    task automatic apply(input logic [63:0] z, x, y, input bit n, rd);
        logic [63:0] ev;
        bit eh, ei;
        string tag;
        expect_of(z, x, y, n, rd, ev, eh, ei, tag);
        @(negedge clk);
        op_z = z; op_x = x; op_y = y; neg_prod = n; rnd_down = rd;
        @(negedge clk);   // R11: one register stage, due after the next rising edge
        checks++;
        if (res_value !== ev || res_handled !== eh || res_invalid !== ei) begin
            errors++;
            $display("FAIL %s (R11 timing) z=%h x=%h y=%h n=%0d rd=%0d: got v=%h h=%0b i=%0b, want v=%h h=%0b i=%0b",
                     tag, z, x, y, n, rd, res_value, res_handled, res_invalid, ev, eh, ei);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, got hung, want finished");
            finish_run();
        end
    end

    initial begin
        logic [63:0] pz, nz, pi, ni, nm;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        checks++;
        if (res_handled !== 1'b0 || res_invalid !== 1'b0 || res_value !== 64'd0) begin
            errors++;
            $display("FAIL R1 reset: got v=%h h=%0b i=%0b, want all zero",
                     res_value, res_handled, res_invalid);
        end
        @(negedge clk); rst_n = 1'b1;
        checks++;
        if (res_handled !== 1'b0 || res_value !== 64'd0) begin
            errors++;
            $display("FAIL R1 after reset: got v=%h h=%0b, want 0 0", res_value, res_handled);
        end

        pz = 64'd0; nz = {1'b1, 63'd0};
        pi = 64'h7FF0_0000_0000_0000; ni = 64'hFFF0_0000_0000_0000;
        nm = 64'h3FF0_0000_0000_0000;

        // R2: z and y signalling, z wins; x and y signalling, x wins
        apply(64'h7FF0_0000_0000_0001, nm, 64'hFFF0_0000_0000_0002, 0, 0);
        apply(nm, 64'h7FF4_0000_0000_0000, 64'h7FF0_0000_0000_0003, 0, 0);
        // R2: signalling y beats quiet z
        apply(64'h7FF8_0000_0000_0005, nm, 64'h7FF0_0000_0000_0007, 0, 0);
        // R3: quiet x before quiet y
        apply(nm, 64'hFFF8_0000_0000_0009, 64'h7FFC_0000_0000_0000, 0, 0);
        // R4: inf*0 both orders
        apply(nm, pi, pz, 0, 0);
        apply(nm, nz, ni, 1, 0);
        // R5: +inf product, -inf z; negate flips to agreement (R6)
        apply(ni, pi, nm, 0, 0);
        apply(ni, pi, nm, 1, 0);
        // R6: product inf, finite z
        apply(nm, ni, nm, 0, 0);
        // R7: finite product, infinite z
        apply(ni, nm, 64'h0000_0000_0000_0001, 0, 0);
        // R8: zero product, finite z and infinite z
        apply(64'hC000_0000_0000_0000, pz, nm, 0, 0);
        apply(pi, nm, nz, 1, 0);
        // R9: signs differ -> +0 / -0 by rounding mode; signs agree -> z
        apply(pz, nz, nm, 0, 0);
        apply(pz, nz, nm, 0, 1);
        apply(nz, nz, nm, 0, 1);
        apply(nz, pz, nm, 1, 0);
        // R10: finite nonzero product, zero z
        apply(pz, nm, nm, 0, 0);

        for (int i = 0; i < 600; i++) begin
            apply(mk($urandom % 6, $urandom % 2), mk($urandom % 6, $urandom % 2),
                  mk($urandom % 6, $urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
        end
        done = 1;
        finish_run();
    end

endmodule